// File: doc/BRIEF.md
# Second-Level Cache Subblock Leakage Mode Controller

This block keeps a power mode for every subblock of a second-level cache. It decides when a subblock is put to sleep and when it is woken, based on events reported by the first-level cache. The data of a subblock that has been copied into the first level exists twice, so the second-level copy can be put into a low-leakage state. Each subblock is in one of three states: powered, retaining (a lowered supply that keeps its contents) or off (no supply, contents lost). A fourth, transient settling state covers the supply ramp after a wake-up.

A 3-bit policy register selects one of five rules. Each rule fixes three things: which event puts a subblock to sleep (a first write that dirties the upper copy, or a fill into the upper level), which sleep state is used, and what wakes the subblock (a direct access to it, or eviction of the matching upper line). For every direct access the controller returns a ready/stall signal and a hit-or-refetch flag. For eviction-driven wake-ups it also returns a write-back request. The storage arrays, tag matching, memory and the supply switches themselves lie outside this block.

Top module: `leak_mode_ctrl`

## Requirements
- R1: After synchronous reset, the policy reads 0, every subblock is powered and holds no valid data, and the first access to any subblock is ready in its own cycle with the refetch flag set.
- R2: An access to a powered subblock is ready in the cycle it is presented. It reports hit if the subblock is valid and refetch otherwise, and exactly one of the two flags is high. When the access completes, the subblock becomes valid.
- R3: Policy 0 (sleep on dirty): a dirty event on a powered subblock turns it off and its contents are lost. A later access stalls, then reports refetch.
- R4: Policy 1 (fill, retain): a fill event on a powered subblock moves it to retaining. A later access stalls, then reports hit.
- R5: Policy 2 (fill, off): a fill event on a powered subblock turns it off. A later access stalls, then reports refetch.
- R6: Policy 3 (fill, retain, wake on eviction): a fill event moves the subblock to retaining, and an eviction event for it starts the wake-up. An access presented k cycles after the eviction cycle stalls for max(0, SETTLE_CYC+1-k) cycles and reports hit.
- R7: Policy 4 (fill, off, write back on eviction): a fill event turns the subblock off. An eviction event for the subblock raises wb_req with wb_idx equal to the evicted index in that same cycle and starts the wake-up. A later access reports hit with the same stall rule as R6.
- R8: A wake-up that begins with an access presented in cycle t raises ready in cycle t+SETTLE_CYC+1. An access that arrives while a wake-up is in progress does not restart it.
- R9: A policy load takes effect only when every subblock is powered and the requested code is 0 to 4. Any other load leaves the policy unchanged.
- R10: Events that the current policy does not use have no effect: dirty under policies 1 to 4, eviction under policies 0 to 2, and any sleep event on a subblock that is not powered.
- R11: Under policy 4, an access and an eviction that target the same off subblock in the same cycle start a single wake-up. wb_req is raised in that cycle, and the access reports hit after SETTLE_CYC+1 stall cycles.
- R12: Fill, dirty and eviction events that target different subblocks in the same cycle each act only on their own subblock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pol_load | input | 1 | Request to load a new policy |
| pol_sel | input | 3 | Requested policy code (0 to 4) |
| pol_cur | output | 3 | Policy in force |
| fill_vld | input | 1 | Subblock data moved into the first level |
| fill_idx | input | IDX_W | Subblock index of the fill |
| dirty_vld | input | 1 | First write made the upper copy dirty |
| dirty_idx | input | IDX_W | Subblock index of the dirty event |
| evict_vld | input | 1 | Matching upper line evicted |
| evict_idx | input | IDX_W | Subblock index of the eviction |
| acc_vld | input | 1 | Direct access request, held until ready |
| acc_idx | input | IDX_W | Subblock index of the access |
| acc_ready | output | 1 | Access completes this cycle |
| acc_hit | output | 1 | Completing access finds valid data |
| acc_refetch | output | 1 | Completing access must refill from memory |
| wb_req | output | 1 | Write back evicted line into the subblock |
| wb_idx | output | IDX_W | Subblock index for the write-back |

## Verification
The case that needs the most care is an access and a wake-up trigger landing on the same subblock in the same cycle. Under policy 4 the bench presents an access and an eviction to one off subblock on the same clock. It expects wb_req in that cycle, a single wake-up of SETTLE_CYC+1 stall cycles, and a hit rather than a refetch. Under policy 3 the bench also sweeps the distance between an eviction and the following access from 0 to 49 cycles. Each stall count is compared with the remaining settling time, calculated arithmetically, to show that the two wake paths do not stack.

// File: rtl/leak_pkg.sv
// Shared types for the subblock leakage controller.
// Assumes: policy codes above POL_LAST are illegal and never stored.
package leak_pkg;

    // Power state of one second-level subblock.
    typedef enum logic [1:0] {
        SB_ON     = 2'd0,
        SB_RETAIN = 2'd1,
        SB_OFF    = 2'd2,
        SB_SETTLE = 2'd3
    } sb_mode_e;

    // Selectable sleep/wake policies.
    typedef enum logic [2:0] {
        POL_ON_DIRTY     = 3'd0,
        POL_FILL_KEEP    = 3'd1,
        POL_FILL_DROP    = 3'd2,
        POL_FILL_KEEP_EW = 3'd3,
        POL_FILL_DROP_EW = 3'd4
    } pol_e;

    localparam int POL_LAST = 4;

    // Decoded action enables for the current policy.
    typedef struct packed {
        logic fill_retain;
        logic fill_off;
        logic dirty_off;
        logic evict_wake;
        logic evict_wb;
    } rule_t;

endpackage

// File: rtl/leak_pol_reg.sv
// Policy register. Loads a new code only while every subblock is powered
// and the code is legal; otherwise the load request is dropped.
// Assumes: all_on_i is the AND of every subblock's powered flag.
module leak_pol_reg
    import leak_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [2:0] sel_i,
    input  logic       all_on_i,
    output pol_e       pol_o
);

    pol_e pol_q;
    logic load_ok;

    // Gate the load on quiescent subblocks and a legal code.
    assign load_ok = load_i && all_on_i && (int'(sel_i) <= POL_LAST);

    // Hold or replace the policy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q <= POL_ON_DIRTY;
        end else if (load_ok) begin
            pol_q <= pol_e'(sel_i);
        end
    end

    assign pol_o = pol_q;

    AST_POL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !all_on_i |=> $stable(pol_q)); // R9
    AST_POL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pol_q) <= POL_LAST); // R9

endmodule

// File: rtl/leak_policy_dec.sv
// Policy decoder: maps the policy code to the sleep/wake actions it enables.
// Assumes: a single shared decoder feeds every subblock.
module leak_policy_dec
    import leak_pkg::*;
(
    input  pol_e  pol_i,
    output rule_t rule_o
);

    // Translate the policy into per-event enables.
    always_comb begin
        rule_o = '0;
        case (pol_i)
            POL_ON_DIRTY: begin
                rule_o.dirty_off = 1'b1;
            end
            POL_FILL_KEEP: begin
                rule_o.fill_retain = 1'b1;
            end
            POL_FILL_DROP: begin
                rule_o.fill_off = 1'b1;
            end
            POL_FILL_KEEP_EW: begin
                rule_o.fill_retain = 1'b1;
                rule_o.evict_wake  = 1'b1;
            end
            POL_FILL_DROP_EW: begin
                rule_o.fill_off   = 1'b1;
                rule_o.evict_wake = 1'b1;
                rule_o.evict_wb   = 1'b1;
            end
            default: begin
                rule_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/leak_subblock.sv
// Per-subblock mode machine: a 2-bit mode, a valid bit and a settling counter.
// Priority inside one cycle, lowest to highest: access completion, fill,
// dirty, eviction wake, access wake. A wake lasts SETTLE_CYC cycles after
// the cycle that starts it.
// Assumes: SETTLE_CYC >= 1 and fits in CNT_W bits.
module leak_subblock
    import leak_pkg::*;
#(
    parameter int SETTLE_CYC = 50,
    parameter int CNT_W      = 6
) (
    input  logic     clk,
    input  logic     rst_n,
    input  rule_t    rule_i,
    input  logic     acc_i,
    input  logic     fill_i,
    input  logic     dirty_i,
    input  logic     evict_i,
    output logic     on_o,
    output logic     valid_o,
    output logic     wb_o
);

    sb_mode_e          mode_q, mode_d;
    logic              valid_q, valid_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              asleep;

    assign asleep = (mode_q == SB_RETAIN) || (mode_q == SB_OFF);

    // Next-state rules for mode, valid and settling counter.
    always_comb begin
        mode_d  = mode_q;
        valid_d = valid_q;
        cnt_d   = cnt_q;
        if (mode_q == SB_SETTLE) begin
            if (cnt_q <= CNT_W'(1)) begin
                mode_d = SB_ON;
                cnt_d  = '0;
            end else begin
                cnt_d = cnt_q - CNT_W'(1);
            end
        end
        if (mode_q == SB_ON) begin
            if (acc_i) begin
                valid_d = 1'b1;
            end
            if (fill_i && rule_i.fill_retain) begin
                mode_d  = SB_RETAIN;
                valid_d = 1'b1;
            end
            if (fill_i && rule_i.fill_off) begin
                mode_d  = SB_OFF;
                valid_d = 1'b0;
            end
            if (dirty_i && rule_i.dirty_off) begin
                mode_d  = SB_OFF;
                valid_d = 1'b0;
            end
        end
        if (evict_i && rule_i.evict_wake && asleep) begin
            mode_d = SB_SETTLE;
            cnt_d  = CNT_W'(SETTLE_CYC);
            if (rule_i.evict_wb) begin
                valid_d = 1'b1;
            end
        end
        if (acc_i && asleep) begin
            mode_d = SB_SETTLE;
            cnt_d  = CNT_W'(SETTLE_CYC);
        end
    end

    // State registers with synchronous reset to powered and invalid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= SB_ON;
            valid_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            mode_q  <= mode_d;
            valid_q <= valid_d;
            cnt_q   <= cnt_d;
        end
    end

    assign on_o    = (mode_q == SB_ON);
    assign valid_o = valid_q;
    assign wb_o    = evict_i && rule_i.evict_wb && (mode_q == SB_OFF);

    AST_OFF_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SB_OFF) |-> !valid_q); // R3
    AST_RETAIN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SB_RETAIN) |-> valid_q); // R4
    AST_SETTLE_END: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SB_SETTLE && cnt_q == CNT_W'(1)) |=> (mode_q == SB_ON)); // R8
    AST_SETTLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SB_SETTLE && cnt_q > CNT_W'(1))
        |=> (mode_q == SB_SETTLE && cnt_q == $past(cnt_q) - CNT_W'(1))); // R8
    AST_ACC_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == SB_SETTLE && cnt_q < CNT_W'(SETTLE_CYC)) |=> (cnt_q != CNT_W'(SETTLE_CYC))); // R8

endmodule

// File: rtl/leak_mode_ctrl.sv
// Top of the subblock leakage controller. Decodes event indices into
// per-subblock strobes, builds one mode machine per subblock, muxes the
// access result and ORs the write-back requests.
// Assumes: acc_vld is held until acc_ready; one event of each kind per cycle.
module leak_mode_ctrl
    import leak_pkg::*;
#(
    parameter  int NUM_SUB    = 8,
    parameter  int SETTLE_CYC = 50,
    localparam int IDX_W      = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pol_load,
    input  logic [2:0]       pol_sel,
    output logic [2:0]       pol_cur,
    input  logic             fill_vld,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic             dirty_vld,
    input  logic [IDX_W-1:0] dirty_idx,
    input  logic             evict_vld,
    input  logic [IDX_W-1:0] evict_idx,
    input  logic             acc_vld,
    input  logic [IDX_W-1:0] acc_idx,
    output logic             acc_ready,
    output logic             acc_hit,
    output logic             acc_refetch,
    output logic             wb_req,
    output logic [IDX_W-1:0] wb_idx
);

    localparam int CNT_W = $clog2(SETTLE_CYC + 1);

    pol_e               pol;
    rule_t              rule;
    logic [NUM_SUB-1:0] on_vec;
    logic [NUM_SUB-1:0] valid_vec;
    logic [NUM_SUB-1:0] wb_vec;
    logic               all_on;
    logic               idx_ok;

    assign all_on = &on_vec;

    leak_pol_reg u_pol (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (pol_load),
        .sel_i    (pol_sel),
        .all_on_i (all_on),
        .pol_o    (pol)
    );

    leak_policy_dec u_dec (
        .pol_i  (pol),
        .rule_o (rule)
    );

    // One mode machine per subblock, each with its own decoded strobes.
    for (genvar g = 0; g < NUM_SUB; g++) begin : g_sub
        logic acc_s, fill_s, dirty_s, evict_s;
        assign acc_s   = acc_vld   && (acc_idx   == IDX_W'(g));
        assign fill_s  = fill_vld  && (fill_idx  == IDX_W'(g));
        assign dirty_s = dirty_vld && (dirty_idx == IDX_W'(g));
        assign evict_s = evict_vld && (evict_idx == IDX_W'(g));

        leak_subblock #(
            .SETTLE_CYC (SETTLE_CYC),
            .CNT_W      (CNT_W)
        ) u_sb (
            .clk     (clk),
            .rst_n   (rst_n),
            .rule_i  (rule),
            .acc_i   (acc_s),
            .fill_i  (fill_s),
            .dirty_i (dirty_s),
            .evict_i (evict_s),
            .on_o    (on_vec[g]),
            .valid_o (valid_vec[g]),
            .wb_o    (wb_vec[g])
        );
    end

    // Access result mux for the addressed subblock.
    assign idx_ok      = int'(acc_idx) < NUM_SUB;
    assign acc_ready   = acc_vld && idx_ok && on_vec[acc_idx];
    assign acc_hit     = acc_ready && valid_vec[acc_idx];
    assign acc_refetch = acc_ready && !valid_vec[acc_idx];

    assign wb_req  = |wb_vec;
    assign wb_idx  = evict_idx;
    assign pol_cur = pol;

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        acc_ready |-> ($countones({acc_hit, acc_refetch}) == 1)); // R2
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_vld |-> (!acc_ready && !acc_hit && !acc_refetch)); // R2
    AST_WB_ONLY_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> (evict_vld && pol == POL_FILL_DROP_EW)); // R7
    AST_WB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wb_vec)); // R7

endmodule

// File: tb/sim_leak_mode_ctrl.sv
module sim_leak_mode_ctrl;

    localparam int N      = 8;
    localparam int SETTLE = 50;
    localparam int IW     = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pol_load = 1'b0;
    logic [2:0]    pol_sel = '0;
    logic [2:0]    pol_cur;
    logic          fill_vld = 1'b0, dirty_vld = 1'b0, evict_vld = 1'b0, acc_vld = 1'b0;
    logic [IW-1:0] fill_idx = '0, dirty_idx = '0, evict_idx = '0, acc_idx = '0;
    logic          acc_ready, acc_hit, acc_refetch, wb_req;
    logic [IW-1:0] wb_idx;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    leak_mode_ctrl #(.NUM_SUB(N), .SETTLE_CYC(SETTLE)) u0 (
        .clk(clk), .rst_n(rst_n), .pol_load(pol_load), .pol_sel(pol_sel),
        .pol_cur(pol_cur), .fill_vld(fill_vld), .fill_idx(fill_idx),
        .dirty_vld(dirty_vld), .dirty_idx(dirty_idx), .evict_vld(evict_vld),
        .evict_idx(evict_idx), .acc_vld(acc_vld), .acc_idx(acc_idx),
        .acc_ready(acc_ready), .acc_hit(acc_hit), .acc_refetch(acc_refetch),
        .wb_req(wb_req), .wb_idx(wb_idx)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 policy after reset", int'(pol_cur), 0);
    endtask

    task automatic set_pol(input int code, input int exp, input string req);
        @(negedge clk);
        pol_load = 1'b1;
        pol_sel  = 3'(code);
        @(negedge clk);
        pol_load = 1'b0;
        #1;
        check(req, int'(pol_cur), exp);
    endtask

    // kind: 0 fill, 1 dirty, 2 evict; exp_wb checked only for evictions
    task automatic pulse(input int kind, input int idx, input int exp_wb);
        @(negedge clk);
        if (kind == 0) begin fill_vld = 1'b1;  fill_idx  = IW'(idx); end
        if (kind == 1) begin dirty_vld = 1'b1; dirty_idx = IW'(idx); end
        if (kind == 2) begin evict_vld = 1'b1; evict_idx = IW'(idx); end
        #1;
        if (kind == 2) begin
            check("R7 wb_req on eviction", int'(wb_req), exp_wb);
            if (exp_wb == 1) check("R7 wb_idx", int'(wb_idx), idx);
        end
        @(negedge clk);
        fill_vld = 1'b0; dirty_vld = 1'b0; evict_vld = 1'b0;
    endtask

    // Present an access, count stall cycles, judge the result flags.
    task automatic access(input int idx, input int exp_stall, input int exp_hit,
                          input int with_ev, input string req);
        int stall;
        @(negedge clk);
        acc_vld = 1'b1;
        acc_idx = IW'(idx);
        if (with_ev == 1) begin
            evict_vld = 1'b1;
            evict_idx = IW'(idx);
        end
        stall = 0;
        #1;
        if (with_ev == 1) check("R11 wb_req with access", int'(wb_req), 1);
        while (!acc_ready && stall < 200) begin
            @(negedge clk);
            evict_vld = 1'b0;
            #1;
            stall++;
        end
        check({req, " stall"}, stall, exp_stall);
        check({req, " hit"}, int'(acc_hit), exp_hit);
        check({req, " refetch"}, int'(acc_refetch), 1 - exp_hit);
        @(negedge clk);
        acc_vld   = 1'b0;
        evict_vld = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // Sweep every policy over every subblock.
        for (int p = 0; p <= 4; p++) begin
            do_reset();
            if (p == 0) begin
                for (int bad = 5; bad <= 7; bad++) set_pol(bad, 0, "R9 illegal code ignored");
            end
            set_pol(p, p, "R9 load when all powered");
            for (int i = 0; i < N; i++) begin
                int k;
                int exp_s;
                access(i, 0, 0, 0, "R1 first access refetch");
                access(i, 0, 1, 0, "R2 powered hit");
                pulse(0, i, 0);
                pulse(1, i, 0);
                if (i == 0) set_pol((p + 1) % 5, p, "R9 load ignored while asleep");
                pulse(2, i, (p == 4) ? 1 : 0);
                if (p >= 3) begin
                    k = i * 7;
                    repeat (k) @(negedge clk);
                    exp_s = (49 - k > 0) ? 49 - k : 0;
                    access(i, exp_s, 1, 0, (p == 3) ? "R6 evict wake" : "R7 evict wake");
                end else if (p == 0) begin
                    access(i, SETTLE + 1, 0, 0, "R3 dirty off refetch R10");
                end else if (p == 1) begin
                    access(i, SETTLE + 1, 1, 0, "R4 retain hit R8 R10");
                end else begin
                    access(i, SETTLE + 1, 0, 0, "R5 off refetch R10");
                end
            end
            if (p == 4) begin
                pulse(0, 2, 0);
                access(2, SETTLE + 1, 1, 1, "R11 access with eviction");
            end
        end

        // R12: fill and dirty to different subblocks in one cycle.
        do_reset();
        access(1, 0, 0, 0, "R12 prep");
        access(2, 0, 0, 0, "R12 prep");
        @(negedge clk);
        fill_vld = 1'b1;  fill_idx  = IW'(1);
        dirty_vld = 1'b1; dirty_idx = IW'(2);
        @(negedge clk);
        fill_vld = 1'b0; dirty_vld = 1'b0;
        access(1, 0, 1, 0, "R12 untouched subblock");
        access(2, SETTLE + 1, 0, 0, "R12 dirtied subblock");

        // R12 and R8: fill one and evict another under policy 3.
        set_pol(3, 3, "R9 reload");
        access(4, 0, 0, 0, "R12 prep");
        access(5, 0, 0, 0, "R12 prep");
        pulse(0, 4, 0);
        pulse(0, 5, 0);
        @(negedge clk);
        evict_vld = 1'b1; evict_idx = IW'(5);
        @(negedge clk);
        evict_vld = 1'b0;
        access(5, 49, 1, 0, "R12 evicted subblock wakes");
        access(4, SETTLE + 1, 1, 0, "R8 other subblock still retained");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule